// File: doc/BRIEF.md
# Dual-Section Digital Phase Comparator with Lock Monitor

This block serves two frequency-synthesizer sections (section 0 = intermediate-frequency loop, section 1 = radio-frequency loop). For each one it takes a divided reference pulse train and a divided feedback pulse train, both sampled on the oscillator clock. It turns their rising-edge order into a charge-pump command: drive high, drive low, or release (high impedance). The sense of that command is set per section, to suit the slope of the VCO and loop filter.

The same edge information gives the phase error in oscillator clocks. Each section keeps a lock state with hysteresis. The two lock results are combined into one flag, and a section held in power-save always counts as locked. A single monitor pin shows either the combined flag or one of the four raw pulse trains, which helps with board bring-up. When a section wakes from power-save, its first comparison may produce only a one-clock correction. A random start phase therefore cannot kick the loop.

Top module: `pc_dual_phase_lock`

## Requirements
- R1: With `pol_pos[i]`=1, a reference edge ahead of the feedback edge drives `cp_hi[i]`, a feedback edge ahead drives `cp_lo[i]`, and with no pending edge neither is asserted. With `pol_pos[i]`=0 the roles of `cp_hi` and `cp_lo` swap. `cp_oe[i]` is high exactly when either is high.
- R2: An input edge takes effect at the first clock that samples it high. If the lagging edge is sampled k clocks after the leading edge, the leading-side output is high for k+1 clocks and the lagging-side output for 1 clock (the last one).
- R3: Edges sampled on the same clock give one clock of `cp_hi` and `cp_lo` together (dead-zone pulse). The two are never high together for two clocks in a row.
- R4: A comparison with error k ≥ UNLOCK_MIN (default 7) clears the section's lock state. Lock is only ever lost at the end of a comparison.
- R5: An unlocked section becomes locked after GOOD_RUN (default 3) consecutive comparisons with error ≤ LOCK_MAX (default 4). An error between the two thresholds restarts that count and leaves a locked section locked.
- R6: With `mon_sel_test`=0, `mon_out` is high only when every section is locked or in power-save.
- R7: With `sec_awake[i]`=0, from the next clock the section's outputs stay released, whatever its inputs do, and the section counts as locked. It is still locked after it wakes.
- R8: In the first comparison after waking, only the first clock of that comparison's output is issued. Later comparisons are not limited.
- R9: With `mon_sel_test`=1, `mon_out` follows {`test_pick[1]`,`test_pick[0]`}: 00 gives ref of section 0, 01 gives ref of section 1, 10 gives feedback of section 0, 11 gives feedback of section 1.
- R10: After reset with both sections awake, all charge-pump outputs are released and `mon_out` (lock flag) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 2 | Divided reference pulse per section |
| fb_pulse | input | 2 | Divided feedback pulse per section |
| pol_pos | input | 2 | Command polarity per section (1 = reference lead drives high) |
| sec_awake | input | 2 | 1 = section active, 0 = power-save |
| mon_sel_test | input | 1 | 0 = monitor shows lock flag, 1 = raw pulse selected by test_pick |
| test_pick | input | 2 | Raw pulse select for the monitor |
| cp_hi | output | 2 | Charge pump drive-high command |
| cp_lo | output | 2 | Charge pump drive-low command |
| cp_oe | output | 2 | Charge pump output enable (0 = high impedance) |
| mon_out | output | 1 | Monitor output |

## Verification
Some properties hold on every cycle and are checked that way. The dead-zone pulse never lasts past one clock. A sleeping section stays released. Lock is only lost or gained at the end of a comparison, or gained on entering power-save. With the flag selected and both sections asleep, the monitor reads high. The remaining behaviour depends on the history of edge offsets, so only the bench scenarios can show it. This covers the pulse widths for every offset and both polarities, the hysteresis band and the consecutive-run rule, the one-clock limit after waking, and the complete monitor select table.

// File: rtl/pc_pkg.sv
package pc_pkg;
   typedef struct packed {
      logic up;   // reference edge pending
      logic dn;   // feedback edge pending
   } pfd_t;

   function automatic logic [1:0] map_polarity(input logic pos, input logic up, input logic dn);
      // returns {hi, lo}
      return pos ? {up, dn} : {dn, up};
   endfunction
endpackage

// File: rtl/pc_phase_front.sv
module pc_phase_front
   import pc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic awake,
   input  logic ref_in,
   input  logic fb_in,
   input  logic pol_pos,
   output pfd_t pfd,
   output logic cmp_done,
   output logic cp_hi,
   output logic cp_lo
);
   logic ref_d, fb_d;
   logic ref_rise, fb_rise;
   pfd_t pfd_q;
   logic first_q, cap_used_q, pass;
   logic up_g, dn_g;

   assign ref_rise = ref_in & ~ref_d;
   assign fb_rise  = fb_in & ~fb_d;
   assign cmp_done = pfd_q.up & pfd_q.dn;

   // edge history keeps tracking during power-save so wake creates no false edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_d <= 1'b0;
         fb_d  <= 1'b0;
      end else begin
         ref_d <= ref_in;
         fb_d  <= fb_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pfd_q <= '0;
      end else if (!awake) begin
         pfd_q <= '0;
      end else if (cmp_done) begin
         pfd_q.up <= ref_rise;
         pfd_q.dn <= fb_rise;
      end else begin
         pfd_q.up <= pfd_q.up | ref_rise;
         pfd_q.dn <= pfd_q.dn | fb_rise;
      end
   end

   // first comparison after wake is limited to one clock of output
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q    <= 1'b0;
         cap_used_q <= 1'b0;
      end else if (!awake) begin
         first_q    <= 1'b1;
         cap_used_q <= 1'b0;
      end else if (cmp_done) begin
         first_q    <= 1'b0;
         cap_used_q <= 1'b0;
      end else if (first_q && (pfd_q.up || pfd_q.dn)) begin
         cap_used_q <= 1'b1;
      end
   end

   assign pass = ~(first_q & cap_used_q);
   assign up_g = pfd_q.up & pass;
   assign dn_g = pfd_q.dn & pass;
   assign {cp_hi, cp_lo} = map_polarity(pol_pos, up_g, dn_g);
   assign pfd = pfd_q;
endmodule

// File: rtl/pc_lock_meter.sv
module pc_lock_meter
   import pc_pkg::*;
#(
   parameter int UNLOCK_MIN = 7,
   parameter int LOCK_MAX   = 4,
   parameter int GOOD_RUN   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic awake,
   input  pfd_t pfd,
   input  logic cmp_done,
   output logic lock_state,
   output logic lock_report
);
   localparam int CNT_W = $clog2(UNLOCK_MIN + 1);
   localparam int RUN_W = $clog2(GOOD_RUN + 1);
   localparam logic [CNT_W-1:0] UNL_V = CNT_W'(UNLOCK_MIN);
   localparam logic [CNT_W-1:0] LMX_V = CNT_W'(LOCK_MAX);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUN - 1);

   logic [CNT_W-1:0] err_q;
   logic [RUN_W-1:0] run_q;
   logic             lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= '0;
         run_q  <= '0;
         lock_q <= 1'b0;
      end else if (!awake) begin
         err_q  <= '0;
         run_q  <= '0;
         lock_q <= 1'b1;
      end else if (cmp_done) begin
         err_q <= '0;
         if (err_q >= UNL_V) begin
            lock_q <= 1'b0;
            run_q  <= '0;
         end else if (err_q <= LMX_V) begin
            if (!lock_q) begin
               if (run_q == RUN_LAST) begin
                  lock_q <= 1'b1;
                  run_q  <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end else begin
            run_q <= '0;
         end
      end else if ((pfd.up ^ pfd.dn) && (err_q != UNL_V)) begin
         err_q <= err_q + 1'b1;
      end
   end

   assign lock_state  = lock_q;
   assign lock_report = lock_q | ~awake;
endmodule

// File: rtl/pc_monitor_mux.sv
module pc_monitor_mux #(
   parameter int SECTIONS = 2
) (
   input  logic [SECTIONS-1:0] lock_report,
   input  logic [SECTIONS-1:0] ref_in,
   input  logic [SECTIONS-1:0] fb_in,
   input  logic                sel_test,
   input  logic [1:0]          pick,
   output logic                mon
);
   logic raw;
   always_comb begin
      unique case (pick)
         2'b00:   raw = ref_in[0];
         2'b01:   raw = ref_in[1];
         2'b10:   raw = fb_in[0];
         default: raw = fb_in[1];
      endcase
   end
   assign mon = sel_test ? raw : &lock_report;
endmodule

// File: rtl/pc_dual_phase_lock.sv
module pc_dual_phase_lock #(
   parameter int UNLOCK_MIN = 7,
   parameter int LOCK_MAX   = 4,
   parameter int GOOD_RUN   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ref_pulse,
   input  logic [1:0] fb_pulse,
   input  logic [1:0] pol_pos,
   input  logic [1:0] sec_awake,
   input  logic       mon_sel_test,
   input  logic [1:0] test_pick,
   output logic [1:0] cp_hi,
   output logic [1:0] cp_lo,
   output logic [1:0] cp_oe,
   output logic       mon_out
);
   import pc_pkg::*;
   localparam int SECTIONS = 2;

   if (LOCK_MAX >= UNLOCK_MIN) begin : g_bad_band
      $error("LOCK_MAX must be below UNLOCK_MIN");
   end
   if (GOOD_RUN < 1) begin : g_bad_run
      $error("GOOD_RUN must be at least 1");
   end
   if (LOCK_MAX < 0) begin : g_bad_lock
      $error("LOCK_MAX must not be negative");
   end

   logic [SECTIONS-1:0] lock_state;
   logic [SECTIONS-1:0] lock_report;
   logic [SECTIONS-1:0] cmp_done;

   for (genvar i = 0; i < SECTIONS; i++) begin : g_sec
      pfd_t pfd;
      pc_phase_front u_front (
         .clk      (clk),
         .rst_n    (rst_n),
         .awake    (sec_awake[i]),
         .ref_in   (ref_pulse[i]),
         .fb_in    (fb_pulse[i]),
         .pol_pos  (pol_pos[i]),
         .pfd      (pfd),
         .cmp_done (cmp_done[i]),
         .cp_hi    (cp_hi[i]),
         .cp_lo    (cp_lo[i])
      );
      pc_lock_meter #(
         .UNLOCK_MIN (UNLOCK_MIN),
         .LOCK_MAX   (LOCK_MAX),
         .GOOD_RUN   (GOOD_RUN)
      ) u_lock (
         .clk         (clk),
         .rst_n       (rst_n),
         .awake       (sec_awake[i]),
         .pfd         (pfd),
         .cmp_done    (cmp_done[i]),
         .lock_state  (lock_state[i]),
         .lock_report (lock_report[i])
      );
      assign cp_oe[i] = cp_hi[i] | cp_lo[i];
   end

   pc_monitor_mux #(.SECTIONS(SECTIONS)) u_mon (
      .lock_report (lock_report),
      .ref_in      (ref_pulse),
      .fb_in       (fb_pulse),
      .sel_test    (mon_sel_test),
      .pick        (test_pick),
      .mon         (mon_out)
   );
endmodule

// File: rtl/pc_dual_phase_lock_chk.sv
module pc_dual_phase_lock_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] sec_awake,
   input logic       mon_sel_test,
   input logic [1:0] cp_hi,
   input logic [1:0] cp_lo,
   input logic [1:0] cp_oe,
   input logic       mon_out,
   input logic [1:0] lock_state,
   input logic [1:0] cmp_done
);
   for (genvar i = 0; i < 2; i++) begin : g_chk
      assert_dz_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cp_hi[i] && cp_lo[i]) |=> !(cp_hi[i] && cp_lo[i]));
      assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!sec_awake[i] && !$past(sec_awake[i])) |-> !cp_oe[i]);
      assert_unlock_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(lock_state[i]) |-> $past(cmp_done[i]));
      assert_relock_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(lock_state[i]) && $past(sec_awake[i])) |-> $past(cmp_done[i]));
   end
   assert_sleepers_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_sel_test && sec_awake == 2'b00) |-> mon_out);
endmodule

bind pc_dual_phase_lock pc_dual_phase_lock_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sec_awake    (sec_awake),
   .mon_sel_test (mon_sel_test),
   .cp_hi        (cp_hi),
   .cp_lo        (cp_lo),
   .cp_oe        (cp_oe),
   .mon_out      (mon_out),
   .lock_state   (lock_state),
   .cmp_done     (cmp_done)
);

// File: tb/pc_dual_phase_lock_test.sv
module pc_dual_phase_lock_test;
   localparam int UNL = 7;
   localparam int LMX = 4;
   localparam int RUN = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_pulse = '0, fb_pulse = '0, pol_pos = 2'b01, sec_awake = 2'b11, test_pick = '0;
   logic       mon_sel_test = 1'b0;
   logic [1:0] cp_hi, cp_lo, cp_oe;
   logic       mon_out;

   int checks = 0, errors = 0;
   bit finished = 0;
   bit mdl_lock [2];
   int mdl_run  [2];

   always #2 clk = ~clk;

   pc_dual_phase_lock #(.UNLOCK_MIN(UNL), .LOCK_MAX(LMX), .GOOD_RUN(RUN)) uut (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
      .pol_pos(pol_pos), .sec_awake(sec_awake), .mon_sel_test(mon_sel_test),
      .test_pick(test_pick), .cp_hi(cp_hi), .cp_lo(cp_lo), .cp_oe(cp_oe), .mon_out(mon_out));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int err_at(input int i);
      case (i)
         3: return 5;  4: return 7;  5: return 2;  6: return 2;  7: return 5;
         8: return 1;  9: return 1; 10: return 1; 11: return 6; 12: return 9;
         13: return 4; 14: return 4; 15: return 4;
         default: return 0;
      endcase
   endfunction

   // one comparison on section s; k = clocks between edges
   task automatic run_cmp(input int s, input bit ref_first, input int k, input bit capped,
                          input string req);
      int hi_n = 0, lo_n = 0, both_n = 0, up_n, dn_n, e;
      int exp_hi, exp_lo;
      for (int c = 0; c < k + 6; c++) begin
         @(negedge clk);
         if (c > 0) begin
            hi_n += int'(cp_hi[s]);
            lo_n += int'(cp_lo[s]);
            both_n += int'(cp_hi[s] & cp_lo[s]);
         end
         if (c == 0) begin
            if (ref_first) ref_pulse[s] = 1'b1; else fb_pulse[s] = 1'b1;
         end
         if (c == k) begin
            if (ref_first) fb_pulse[s] = 1'b1; else ref_pulse[s] = 1'b1;
         end
         if (c == k + 3) begin
            ref_pulse[s] = 1'b0;
            fb_pulse[s]  = 1'b0;
         end
      end
      if (capped) begin
         up_n = ref_first ? 1 : (k == 0 ? 1 : 0);
         dn_n = ref_first ? (k == 0 ? 1 : 0) : 1;
      end else begin
         up_n = ref_first ? k + 1 : 1;
         dn_n = ref_first ? 1 : k + 1;
      end
      exp_hi = pol_pos[s] ? up_n : dn_n;
      exp_lo = pol_pos[s] ? dn_n : up_n;
      check({req, " hi-pulse"}, hi_n, exp_hi);
      check({req, " lo-pulse"}, lo_n, exp_lo);
      if (!capped) check({req, " R3 overlap"}, both_n, 1);
      // lock model
      e = (k >= UNL) ? UNL : k;
      if (e >= UNL) begin
         mdl_lock[s] = 0; mdl_run[s] = 0;
      end else if (e <= LMX) begin
         if (!mdl_lock[s]) begin
            mdl_run[s]++;
            if (mdl_run[s] == RUN) begin mdl_lock[s] = 1; mdl_run[s] = 0; end
         end else mdl_run[s] = 0;
      end else mdl_run[s] = 0;
   endtask

   initial begin
      for (int i = 0; i < 60000; i++) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      mdl_lock[0] = 0; mdl_lock[1] = 0; mdl_run[0] = 0; mdl_run[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 cp_oe", int'(cp_oe), 0);
      check("R10 lock flag", int'(mon_out), 0);

      // section 0 sweep, section 1 asleep (counts locked)
      sec_awake = 2'b01; pol_pos = 2'b01;
      mdl_lock[1] = 1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         run_cmp(0, (i % 2) == 0, err_at(i), 0, "R1 R2 sec0");
         @(negedge clk);
         check("R4 R5 sec0 lock", int'(mon_out), int'(mdl_lock[0]));
      end

      // section 1 sweep, polarity negative, first comparison after wake capped
      sec_awake = 2'b10; pol_pos = 2'b00;
      mdl_lock[0] = 1; mdl_run[1] = 0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         run_cmp(1, (i % 2) == 1, err_at(i), i == 0, i == 0 ? "R8 sec1" : "R1 R2 sec1");
         @(negedge clk);
         check("R4 R5 sec1 lock", int'(mon_out), int'(mdl_lock[1]));
      end

      // R6: both awake, both locked; then unlock section 1
      sec_awake = 2'b11; pol_pos = 2'b01;
      repeat (2) @(negedge clk);
      run_cmp(0, 1, 0, 1, "R8 R3 sec0 coincident");
      @(negedge clk);
      check("R6 both locked", int'(mon_out), 1);
      run_cmp(1, 0, 9, 0, "R4 sec1");
      @(negedge clk);
      check("R6 one unlocked", int'(mon_out), 0);

      // R7: sleep section 1 while feeding it edges
      sec_awake = 2'b01;
      @(negedge clk);
      begin
         int act = 0;
         for (int c = 0; c < 12; c++) begin
            ref_pulse[1] = (c % 4) < 2;
            fb_pulse[1]  = (c % 5) < 2;
            @(negedge clk);
            act += int'(cp_oe[1]);
         end
         ref_pulse[1] = 0; fb_pulse[1] = 0;
         check("R7 sleep released", act, 0);
      end
      check("R7 R6 sleeper locked", int'(mon_out), 1);

      // R8: wake section 1, first comparison capped, then normal; still locked after wake
      sec_awake = 2'b11;
      mdl_lock[1] = 1; mdl_run[1] = 0;
      repeat (2) @(negedge clk);
      check("R7 locked after wake", int'(mon_out), 1);
      run_cmp(1, 1, 5, 1, "R8 wake cap");
      run_cmp(1, 1, 2, 0, "R8 uncapped after");
      @(negedge clk);
      check("R6 after wake", int'(mon_out), int'(mdl_lock[0] & mdl_lock[1]));

      // R9: monitor test select sweep, sections asleep
      sec_awake = 2'b00; mon_sel_test = 1'b1;
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
         for (int v = 0; v < 16; v++) begin
            logic [3:0] vv;
            int exp;
            vv = 4'(v);
            test_pick = 2'(p);
            ref_pulse = vv[1:0];
            fb_pulse  = vv[3:2];
            #1;
            exp = int'(vv[p]);
            check("R9 monitor select", int'(mon_out), exp);
         end
      end
      ref_pulse = 0; fb_pulse = 0; mon_sel_test = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R6 all asleep", int'(mon_out), 1);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule